// File: doc/BRIEF.md
# DisplayPort AUX Transaction Controller

This controller turns one caller request into a DisplayPort AUX request header and payload, hands it to a request/reply channel, and reads the reply to decide the outcome. A request is either a native access to the 20-bit sink configuration space (read or write of up to 16 bytes) or a single-byte I2C-over-AUX transfer. When the sink asks the source to come back later, the controller holds off for a fixed interval and reissues the identical request, within a per-kind attempt budget. The result is a byte count or one error code.

The AUX wire itself is not modelled. A channel model accepts the header and payload on a one-cycle `ch_req` strobe and answers with one `ch_rsp_valid` beat carrying a channel status, the reply byte, a returned length and the returned data. A channel timeout appears as a status value. Only one transaction runs at a time. While `busy` is high, request strobes are dropped.

Top module: `aux_xact_ctrl`

## Requirements
- R1: The header `ch_hdr` carries address bits 7:0 in [7:0], address bits 15:8 in [15:8], address bits 19:16 in [19:16], the command nibble in [23:20], and a length byte in [31:24]. The command is 8 for a native write and 9 for a native read (`req_op` 0 and 1). A native write has the length byte ((len+4) mod 16)<<4 | (len-1), `ch_msg_len` = len+4 and the payload `req_wdata`. A native read has 0x40 | (len-1), `ch_msg_len` 4 and a zero payload.
- R2: A native write with `req_len` above 16 never raises `ch_req`. It completes in the cycle after acceptance with error code 7.
- R3: A channel status of 1, 2 or 3 ends the transaction at once with error code 1 (timeout), 2 (busy flags) or 3 (channel error), with no retry. This holds on any attempt.
- R4: Reply bits 5:4 are the native reply: 0 ACK, 1 NACK, 2 DEFER, 3 invalid. After a DEFER the next `ch_req` comes exactly CYC_PER_US*DEFER_US cycles after the reply beat, with the same header. A native write that gets an ACK returns a count equal to `req_len` and error 0.
- R5: A native NACK or an invalid native reply gives error 4. A native DEFER on attempt NATIVE_TRIES also gives error 4.
- R6: For I2C requests (`req_op` 2 write, 3 read), a native NACK or an invalid native reply gives error 6 whatever bits 7:6 hold. A native DEFER retries and uses one attempt. Bits 7:6 are read only under a native ACK.
- R7: Reply bits 7:6 are the I2C reply: 0 ACK, 1 NACK, 2 DEFER, 3 invalid. I2C ACK gives error 0 and a count of min(returned length, 1). I2C NACK or invalid gives error 6. A DEFER of either kind on attempt I2C_TRIES gives error 6.
- R8: The I2C command nibble is 0 for a write and 1 for a read, plus 4 unless `req_stop` is set. A write sends length byte 0x50, `ch_msg_len` 5 and `req_wdata[7:0]` as its only payload byte. A read sends 0x40 and `ch_msg_len` 4.
- R9: A native read whose completed reply returns length 0 gives error 5. Otherwise the count is min(returned length, `req_len`). `rd_data` holds the returned bytes below the count and zero above. An I2C read that succeeds places the returned byte in `rd_data[7:0]`. After any error, `rd_data` is zero.
- R10: After reset, `busy`, `done` and `ch_req` are low. `ch_req` and `done` are single-cycle pulses. Request strobes seen while `busy` is high are ignored. `busy` falls after `done`, and `ch_req` stays low until a new request arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, accepted when not busy |
| req_op | input | 2 | 0 native write, 1 native read, 2 I2C write, 3 I2C read |
| req_stop | input | 1 | I2C: end the I2C transaction (clears the middle flag) |
| req_addr | input | 20 | Sink address (native) or device address (I2C) |
| req_len | input | 5 | Native byte count, 1 to 16 |
| req_wdata | input | 128 | Write payload, byte 0 in bits 7:0 |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| done_err | output | 3 | Error code (0 means success) |
| done_count | output | 5 | Byte count of a successful transaction |
| rd_data | output | 128 | Read data, byte 0 in bits 7:0 |
| ch_req | output | 1 | One-cycle issue strobe to the channel |
| ch_hdr | output | 32 | Four-byte request header |
| ch_msg_len | output | 5 | Total message length in bytes |
| ch_payload | output | 128 | Request payload bytes |
| ch_rsp_valid | input | 1 | Reply beat from the channel |
| ch_rsp_status | input | 8 | Channel status: 1 timeout, 2 busy flags, 3 error, other values complete |
| ch_rsp_reply | input | 8 | Reply byte: bits 5:4 native, bits 7:6 I2C |
| ch_rsp_len | input | 5 | Number of bytes returned |
| ch_rsp_data | input | 128 | Returned bytes |

## Verification
Two decisions can land on the same reply beat. The first is a retry decision, from a DEFER in either reply field. The second is a terminal decision, from an exhausted attempt budget, a channel status error, or a zero-length native read. The bench provokes the overlap with scripts that defer exactly up to the native or I2C budget, that return a timeout right after a defer, and that defer natively while the I2C field shows NACK. A reference model walks the same script arithmetically and judges the final error code, the number of `ch_req` issues, and the hold-off gap before each reissue.

// File: rtl/aux_xact_pkg.sv
package aux_xact_pkg;
    localparam int MAX_PAYLOAD = 16;
    localparam int BYTE_W      = 8;
    localparam int DATA_W      = MAX_PAYLOAD * BYTE_W;
    localparam int LEN_W       = $clog2(MAX_PAYLOAD + 1);
    localparam int ADDR_W      = 20;
    localparam int HDR_W       = 4 * BYTE_W;

    localparam logic [7:0] CH_TIMEOUT = 8'd1;
    localparam logic [7:0] CH_FLAGS   = 8'd2;
    localparam logic [7:0] CH_FAULT   = 8'd3;

    typedef enum logic [1:0] {
        OP_NWR = 2'd0,
        OP_NRD = 2'd1,
        OP_IWR = 2'd2,
        OP_IRD = 2'd3
    } aux_op_e;

    typedef enum logic [2:0] {
        E_OK       = 3'd0,
        E_TIMEOUT  = 3'd1,
        E_FLAGS    = 3'd2,
        E_CHAN     = 3'd3,
        E_IO       = 3'd4,
        E_PROTO    = 3'd5,
        E_REMOTE   = 3'd6,
        E_TOO_LONG = 3'd7
    } aux_err_e;

    typedef enum logic [1:0] {
        RP_ACK   = 2'd0,
        RP_NACK  = 2'd1,
        RP_DEFER = 2'd2,
        RP_BAD   = 2'd3
    } aux_rply_e;

    typedef enum logic [2:0] {
        S_IDLE, S_ISSUE, S_WAIT, S_BACK, S_DONE
    } aux_state_e;

    typedef struct packed {
        aux_op_e            op;
        logic               stop;
        logic [ADDR_W-1:0]  addr;
        logic [LEN_W-1:0]   len;
        logic [DATA_W-1:0]  wdata;
    } aux_req_t;

    typedef struct packed {
        logic             retry;
        aux_err_e         err;
        logic [LEN_W-1:0] count;
    } aux_verdict_t;

    function automatic logic is_native(aux_op_e op);
        return (op == OP_NWR) || (op == OP_NRD);
    endfunction

    function automatic logic [3:0] cmd_nibble(aux_op_e op, logic stop);
        logic [3:0] c;
        case (op)
            OP_NWR:  c = 4'h8;
            OP_NRD:  c = 4'h9;
            OP_IWR:  c = stop ? 4'h0 : 4'h4;
            default: c = stop ? 4'h1 : 4'h5;
        endcase
        return c;
    endfunction

    function automatic logic [LEN_W-1:0] min_len(logic [LEN_W-1:0] a, logic [LEN_W-1:0] b);
        return (a < b) ? a : b;
    endfunction
endpackage

// File: rtl/aux_hdr_build.sv
module aux_hdr_build
    import aux_xact_pkg::*;
(
    input  aux_req_t           req,
    output logic [HDR_W-1:0]   hdr,
    output logic [LEN_W-1:0]   msg_len,
    output logic [DATA_W-1:0]  payload
);
    logic [LEN_W-1:0] len_m1;
    logic [LEN_W-1:0] wr_total;
    logic [7:0]       len_byte;

    always_comb begin
        len_m1   = req.len - LEN_W'(1);
        wr_total = req.len + LEN_W'(4);
        case (req.op)
            OP_NWR: begin
                len_byte = {wr_total[3:0], len_m1[3:0]};
                msg_len  = wr_total;
                payload  = req.wdata;
            end
            OP_NRD: begin
                len_byte = {4'h4, len_m1[3:0]};
                msg_len  = LEN_W'(4);
                payload  = '0;
            end
            OP_IWR: begin
                len_byte = 8'h50;
                msg_len  = LEN_W'(5);
                payload  = DATA_W'(req.wdata[7:0]);
            end
            default: begin
                len_byte = 8'h40;
                msg_len  = LEN_W'(4);
                payload  = '0;
            end
        endcase
        hdr = {len_byte, cmd_nibble(req.op, req.stop), req.addr[19:16],
               req.addr[15:8], req.addr[7:0]};
    end
endmodule

// File: rtl/aux_reply_eval.sv
module aux_reply_eval
    import aux_xact_pkg::*;
#(
    parameter int NATIVE_TRIES = 8,
    parameter int I2C_TRIES    = 4,
    parameter int TRY_W        = 4
) (
    input  aux_op_e           op,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [TRY_W-1:0]  tries,
    input  logic [7:0]        status,
    input  logic [3:0]        reply_hi,
    input  logic [LEN_W-1:0]  rsp_len,
    output aux_verdict_t      verdict
);
    aux_rply_e nat;
    aux_rply_e sub;
    logic      spent;

    always_comb begin
        nat   = aux_rply_e'(reply_hi[1:0]);
        sub   = aux_rply_e'(reply_hi[3:2]);
        spent = is_native(op) ? (tries >= TRY_W'(NATIVE_TRIES))
                              : (tries >= TRY_W'(I2C_TRIES));
        verdict = '{retry: 1'b0, err: E_OK, count: '0};
        if (status == CH_TIMEOUT) begin
            verdict.err = E_TIMEOUT;
        end else if (status == CH_FLAGS) begin
            verdict.err = E_FLAGS;
        end else if (status == CH_FAULT) begin
            verdict.err = E_CHAN;
        end else if (is_native(op)) begin
            if (op == OP_NRD && rsp_len == '0) begin
                verdict.err = E_PROTO;
            end else begin
                case (nat)
                    RP_ACK:   verdict.count = (op == OP_NWR) ? req_len : min_len(rsp_len, req_len);
                    RP_DEFER: begin
                        if (spent) verdict.err = E_IO;
                        else       verdict.retry = 1'b1;
                    end
                    default:  verdict.err = E_IO;
                endcase
            end
        end else begin
            case (nat)
                RP_ACK: begin
                    case (sub)
                        RP_ACK:   verdict.count = min_len(rsp_len, LEN_W'(1));
                        RP_DEFER: begin
                            if (spent) verdict.err = E_REMOTE;
                            else       verdict.retry = 1'b1;
                        end
                        default:  verdict.err = E_REMOTE;
                    endcase
                end
                RP_DEFER: begin
                    if (spent) verdict.err = E_REMOTE;
                    else       verdict.retry = 1'b1;
                end
                default: verdict.err = E_REMOTE;
            endcase
        end
    end
endmodule

// File: rtl/aux_backoff_timer.sv
module aux_backoff_timer #(
    parameter int WAIT_CYC = 400
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic hit
);
    localparam int CNT_W = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;

    logic [CNT_W-1:0] cnt;

    assign hit = run && (cnt == CNT_W'(WAIT_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst || !run || hit) cnt <= '0;
        else                    cnt <= cnt + CNT_W'(1);
    end
endmodule

// File: rtl/aux_xact_ctrl.sv
module aux_xact_ctrl
    import aux_xact_pkg::*;
#(
    parameter int CYC_PER_US   = 100,
    parameter int DEFER_US     = 400,
    parameter int NATIVE_TRIES = 8,
    parameter int I2C_TRIES    = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req_valid,
    input  logic [1:0]             req_op,
    input  logic                   req_stop,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [LEN_W-1:0]       req_len,
    input  logic [DATA_W-1:0]      req_wdata,
    output logic                   busy,
    output logic                   done,
    output logic [2:0]             done_err,
    output logic [LEN_W-1:0]       done_count,
    output logic [DATA_W-1:0]      rd_data,
    output logic                   ch_req,
    output logic [HDR_W-1:0]       ch_hdr,
    output logic [LEN_W-1:0]       ch_msg_len,
    output logic [DATA_W-1:0]      ch_payload,
    input  logic                   ch_rsp_valid,
    input  logic [7:0]             ch_rsp_status,
    input  logic [7:0]             ch_rsp_reply,
    input  logic [LEN_W-1:0]       ch_rsp_len,
    input  logic [DATA_W-1:0]      ch_rsp_data
);
    localparam int WAIT_CYC = CYC_PER_US * DEFER_US;
    localparam int TRY_MAX  = (NATIVE_TRIES > I2C_TRIES) ? NATIVE_TRIES : I2C_TRIES;
    localparam int TRY_W    = $clog2(TRY_MAX + 1);

    aux_state_e        state;
    aux_req_t          req_in, req_q;
    logic [TRY_W-1:0]  tries;
    aux_verdict_t      verdict;
    logic              back_hit;
    logic              too_long;
    logic [DATA_W-1:0] rd_next;
    aux_err_e          err_q;

    always_comb begin
        req_in.op    = aux_op_e'(req_op);
        req_in.stop  = req_stop;
        req_in.addr  = req_addr;
        req_in.len   = req_len;
        req_in.wdata = req_wdata;
        too_long     = (req_in.op == OP_NWR) && (req_len > LEN_W'(MAX_PAYLOAD));
    end

    aux_hdr_build u_hdr (
        .req     (req_q),
        .hdr     (ch_hdr),
        .msg_len (ch_msg_len),
        .payload (ch_payload)
    );

    aux_reply_eval #(
        .NATIVE_TRIES (NATIVE_TRIES),
        .I2C_TRIES    (I2C_TRIES),
        .TRY_W        (TRY_W)
    ) u_eval (
        .op       (req_q.op),
        .req_len  (req_q.len),
        .tries    (tries),
        .status   (ch_rsp_status),
        .reply_hi (ch_rsp_reply[7:4]),
        .rsp_len  (ch_rsp_len),
        .verdict  (verdict)
    );

    aux_backoff_timer #(.WAIT_CYC(WAIT_CYC)) u_backoff (
        .clk (clk),
        .rst (rst),
        .run (state == S_BACK),
        .hit (back_hit)
    );

    // Per-byte selection of returned data
    for (genvar g = 0; g < MAX_PAYLOAD; g++) begin : g_rbyte
        logic keep;
        assign keep = (verdict.err == E_OK) &&
                      (((req_q.op == OP_NRD) && (LEN_W'(g) < verdict.count)) ||
                       ((req_q.op == OP_IRD) && (g == 0)));
        assign rd_next[g*BYTE_W +: BYTE_W] = keep ? ch_rsp_data[g*BYTE_W +: BYTE_W] : 8'h00;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= S_IDLE;
            req_q      <= '0;
            tries      <= '0;
            err_q      <= E_OK;
            done_count <= '0;
            rd_data    <= '0;
        end else begin
            case (state)
                S_IDLE: begin
                    if (req_valid) begin
                        req_q <= req_in;
                        tries <= '0;
                        if (too_long) begin
                            err_q      <= E_TOO_LONG;
                            done_count <= '0;
                            rd_data    <= '0;
                            state      <= S_DONE;
                        end else begin
                            state <= S_ISSUE;
                        end
                    end
                end
                S_ISSUE: begin
                    tries <= tries + TRY_W'(1);
                    state <= S_WAIT;
                end
                S_WAIT: begin
                    if (ch_rsp_valid) begin
                        if (verdict.retry) begin
                            state <= S_BACK;
                        end else begin
                            err_q      <= verdict.err;
                            done_count <= verdict.count;
                            rd_data    <= rd_next;
                            state      <= S_DONE;
                        end
                    end
                end
                S_BACK: begin
                    if (back_hit) state <= S_ISSUE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign busy     = (state != S_IDLE);
    assign done     = (state == S_DONE);
    assign ch_req   = (state == S_ISSUE);
    assign done_err = err_q;
endmodule

// File: rtl/aux_xact_chk.sv
module aux_xact_chk (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        done,
    input logic [2:0]  done_err,
    input logic        ch_req,
    input logic [31:0] ch_hdr,
    input logic        ch_rsp_valid,
    input logic [7:0]  ch_rsp_status
);
    // R10: issue strobe lasts one cycle
    p_issue_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        ch_req |=> !ch_req);

    // R10: completion strobe lasts one cycle
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10: an issue only happens inside a transaction
    p_issue_busy_r10: assert property (@(posedge clk) disable iff (rst)
        ch_req |-> busy);

    // R2: an oversize write completes straight from idle, with no issue
    p_reject_direct_r2: assert property (@(posedge clk) disable iff (rst)
        (done && done_err == 3'd7) |-> !$past(busy));

    // R4: the header is held for the whole transaction, retries included
    p_hdr_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(ch_hdr));

    // R3: a channel status error ends the transaction on the next cycle
    p_status_abort_r3: assert property (@(posedge clk) disable iff (rst)
        (busy && !ch_req && !done && ch_rsp_valid &&
         (ch_rsp_status == 8'd1 || ch_rsp_status == 8'd2 || ch_rsp_status == 8'd3))
        |=> (done && done_err == $past(ch_rsp_status[2:0])));
endmodule

bind aux_xact_ctrl aux_xact_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .busy          (busy),
    .done          (done),
    .done_err      (done_err),
    .ch_req        (ch_req),
    .ch_hdr        (ch_hdr),
    .ch_rsp_valid  (ch_rsp_valid),
    .ch_rsp_status (ch_rsp_status)
);

// File: tb/aux_xact_ctrl_bench.sv
module aux_xact_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CPU  = 2;
    localparam int DUS  = 5;
    localparam int WAIT = CPU * DUS;
    localparam int NT   = 3;
    localparam int IT   = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req_valid = 1'b0;
    logic [1:0]   req_op = 2'd0;
    logic         req_stop = 1'b0;
    logic [19:0]  req_addr = '0;
    logic [4:0]   req_len = '0;
    logic [127:0] req_wdata = '0;
    logic         busy, done;
    logic [2:0]   done_err;
    logic [4:0]   done_count;
    logic [127:0] rd_data;
    logic         ch_req;
    logic [31:0]  ch_hdr;
    logic [4:0]   ch_msg_len;
    logic [127:0] ch_payload;
    logic         ch_rsp_valid = 1'b0;
    logic [7:0]   ch_rsp_status = '0;
    logic [7:0]   ch_rsp_reply = '0;
    logic [4:0]   ch_rsp_len = '0;
    logic [127:0] ch_rsp_data = '0;

    int nvec = 0;
    int nfail = 0;
    int cyc = 0;

    logic [7:0] sc_st [8];
    logic [7:0] sc_rp [8];
    logic [4:0] sc_ln [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    aux_xact_ctrl #(
        .CYC_PER_US(CPU), .DEFER_US(DUS), .NATIVE_TRIES(NT), .I2C_TRIES(IT)
    ) u_aux_xact_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_stop(req_stop), .req_addr(req_addr), .req_len(req_len),
        .req_wdata(req_wdata), .busy(busy), .done(done), .done_err(done_err),
        .done_count(done_count), .rd_data(rd_data), .ch_req(ch_req),
        .ch_hdr(ch_hdr), .ch_msg_len(ch_msg_len), .ch_payload(ch_payload),
        .ch_rsp_valid(ch_rsp_valid), .ch_rsp_status(ch_rsp_status),
        .ch_rsp_reply(ch_rsp_reply), .ch_rsp_len(ch_rsp_len),
        .ch_rsp_data(ch_rsp_data)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            nfail = nfail + 1;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    task automatic chk(input string tag, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic sc_fill(input logic [7:0] st, input logic [7:0] rp, input logic [4:0] ln);
        for (int i = 0; i < 8; i++) begin
            sc_st[i] = st; sc_rp[i] = rp; sc_ln[i] = ln;
        end
    endtask

    task automatic sc_set(input int i, input logic [7:0] st, input logic [7:0] rp, input logic [4:0] ln);
        sc_st[i] = st; sc_rp[i] = rp; sc_ln[i] = ln;
    endtask

    // Reference walk through the reply script
    task automatic model(input int op, input int len, output int e, output int c, output int iss);
        int nf, sf, ln, lim;
        e = 0; c = 0; iss = 0;
        if (op == 0 && len > 16) begin e = 7; return; end
        lim = (op < 2) ? NT : IT;
        for (int a = 1; a <= 8; a++) begin
            iss = a;
            nf = int'(sc_rp[a-1][5:4]);
            sf = int'(sc_rp[a-1][7:6]);
            ln = int'(sc_ln[a-1]);
            if (sc_st[a-1] >= 1 && sc_st[a-1] <= 3) begin e = int'(sc_st[a-1]); return; end
            if (op < 2) begin
                if (op == 1 && ln == 0) begin e = 5; return; end
                if (nf == 0) begin c = (op == 0) ? len : ((ln < len) ? ln : len); return; end
                if (nf != 2 || a >= lim) begin e = 4; return; end
            end else begin
                if (nf == 0) begin
                    if (sf == 0) begin c = (ln < 1) ? ln : 1; return; end
                    if (sf != 2 || a >= lim) begin e = 6; return; end
                end else if (nf != 2 || a >= lim) begin
                    e = 6; return;
                end
            end
        end
    endtask

    task automatic run_x(input int op, input logic stop, input logic [19:0] addr,
                         input int len, input logic [7:0] seed, input bit poke,
                         input string tag);
        int e, c, iss, n_iss, k, cmd, mlen;
        logic [7:0]   b3;
        logic [31:0]  ehdr;
        logic [127:0] wd, rdat, epay, erd;
        string htag, gtag;
        for (int i = 0; i < 16; i++) begin
            wd[i*8 +: 8]   = seed ^ 8'(i * 7);
            rdat[i*8 +: 8] = seed + 8'h40 + 8'(i);
        end
        model(op, len, e, c, iss);
        case (op)
            0: begin cmd = 8; b3 = {4'((len + 4) % 16), 4'(len - 1)}; mlen = len + 4; epay = wd; end
            1: begin cmd = 9; b3 = {4'h4, 4'(len - 1)}; mlen = 4; epay = '0; end
            2: begin cmd = stop ? 0 : 4; b3 = 8'h50; mlen = 5; epay = {120'b0, wd[7:0]}; end
            default: begin cmd = stop ? 1 : 5; b3 = 8'h40; mlen = 4; epay = '0; end
        endcase
        ehdr = {b3, 4'(cmd), addr[19:16], addr[15:8], addr[7:0]};
        htag = (op < 2) ? "R1" : "R8";
        gtag = (op < 2) ? "R4" : "R7";
        erd  = '0;
        if (e == 0 && op == 1)
            for (int i = 0; i < 16; i++) if (i < c) erd[i*8 +: 8] = rdat[i*8 +: 8];
        if (e == 0 && op == 3) erd[7:0] = rdat[7:0];

        @(negedge clk);
        req_op = 2'(op); req_stop = stop; req_addr = addr; req_len = 5'(len);
        req_wdata = wd; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        n_iss = 0;
        while (!done) begin
            if (ch_req) begin
                n_iss++;
                chk(htag, "header", 128'(ch_hdr), 128'(ehdr));
                chk(htag, "msg length", 128'(ch_msg_len), 128'(mlen));
                chk(htag, "payload", ch_payload, epay);
                @(negedge clk);
                if (poke) begin
                    req_valid = 1'b1; req_op = 2'(3 - op); req_addr = ~addr;
                end
                @(negedge clk);
                req_valid = 1'b0;
                ch_rsp_status = sc_st[(n_iss > 8) ? 7 : n_iss - 1];
                ch_rsp_reply  = sc_rp[(n_iss > 8) ? 7 : n_iss - 1];
                ch_rsp_len    = sc_ln[(n_iss > 8) ? 7 : n_iss - 1];
                ch_rsp_data   = rdat;
                ch_rsp_valid  = 1'b1;
                @(negedge clk);
                ch_rsp_valid = 1'b0;
                k = 0;
                while (!done && !ch_req) begin @(negedge clk); k++; end
                if (ch_req) chk(gtag, "defer gap", 128'(k), 128'(WAIT));
            end else begin
                @(negedge clk);
            end
        end
        chk(tag, "error code", 128'(done_err), 128'(e));
        chk(tag, "issue count", 128'(n_iss), 128'(iss));
        if (e == 0) chk(tag, "byte count", 128'(done_count), 128'(c));
        chk((op == 1 || op == 3) ? "R9" : tag, "read data", rd_data, erd);
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            chk("R10", "idle after done", {125'b0, busy, done, ch_req}, 128'b0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R10", "reset outputs", {125'b0, busy, done, ch_req}, 128'b0);

        // Native write, every length including the oversize one
        sc_fill(8'h00, 8'h00, 5'd0);
        for (int len = 1; len <= 17; len++)
            run_x(0, 1'b0, 20'hA5C30 + 20'(len * 4099), len, 8'(len), 1'b0, (len > 16) ? "R2" : "R4");

        // Native read, returned length exact, longer, zero
        for (int len = 1; len <= 16; len++) begin
            sc_fill(8'h00, 8'h00, 5'(len));
            run_x(1, 1'b0, 20'h0_0200 + 20'(len), len, 8'(3 * len), 1'b0, "R9");
            sc_fill(8'h00, 8'h00, 5'(len + 3));
            run_x(1, 1'b0, 20'hF_0000 + 20'(len), len, 8'(5 * len), 1'b0, "R9");
        end
        sc_fill(8'h00, 8'h00, 5'd0);
        run_x(1, 1'b0, 20'h00101, 4, 8'h11, 1'b0, "R9");

        // Channel status errors on every kind
        for (int op = 0; op < 4; op++)
            for (int st = 1; st <= 3; st++) begin
                sc_fill(8'(st), 8'h00, 5'd1);
                run_x(op, 1'b1, 20'h12345, 2, 8'(op * 16 + st), 1'b0, "R3");
            end
        // Timeout on the attempt after a defer
        sc_fill(8'h01, 8'h00, 5'd1);
        sc_set(0, 8'h00, 8'h20, 5'd1);
        run_x(1, 1'b0, 20'h00300, 3, 8'h33, 1'b0, "R3");

        // Native defers up to and past the budget
        for (int op = 0; op < 2; op++)
            for (int d = 1; d <= NT; d++) begin
                sc_fill(8'h00, 8'h00, 5'd8);
                for (int i = 0; i < d; i++) sc_set(i, 8'h00, 8'h20, 5'd8);
                run_x(op, 1'b0, 20'h54321, 8, 8'(d), 1'b0, (d >= NT) ? "R5" : "R4");
            end
        // Native NACK and invalid
        for (int op = 0; op < 2; op++) begin
            sc_fill(8'h00, 8'h10, 5'd2);
            run_x(op, 1'b0, 20'h00010, 2, 8'h21, 1'b0, "R5");
            sc_fill(8'h00, 8'h30, 5'd2);
            run_x(op, 1'b0, 20'h00010, 2, 8'h22, 1'b0, "R5");
        end

        // I2C: defers in the I2C field, both directions, with and without stop
        for (int op = 2; op < 4; op++)
            for (int s = 0; s < 2; s++)
                for (int d = 0; d <= IT; d++) begin
                    sc_fill(8'h00, 8'h00, 5'd1);
                    for (int i = 0; i < d; i++) sc_set(i, 8'h00, 8'h80, 5'd1);
                    run_x(op, 1'(s), 20'h00050, 1, 8'(op * 32 + s * 8 + d), 1'b0,
                          (d >= IT) ? "R7" : "R8");
                end
        // I2C: native defer counts as an attempt, I2C bits ignored there
        for (int op = 2; op < 4; op++) begin
            sc_fill(8'h00, 8'h00, 5'd1);
            sc_set(0, 8'h00, 8'h60, 5'd1);
            sc_set(1, 8'h00, 8'h80, 5'd1);
            sc_set(2, 8'h00, 8'hE0, 5'd1);
            run_x(op, 1'b0, 20'h00050, 1, 8'h70, 1'b0, "R6");
            sc_fill(8'h00, 8'h20, 5'd1);
            run_x(op, 1'b0, 20'h00050, 1, 8'h71, 1'b0, "R6");
            sc_fill(8'h00, 8'h10, 5'd1);
            run_x(op, 1'b1, 20'h00050, 1, 8'h72, 1'b0, "R6");
            sc_fill(8'h00, 8'h70, 5'd1);
            run_x(op, 1'b1, 20'h00050, 1, 8'h73, 1'b0, "R6");
            sc_fill(8'h00, 8'h40, 5'd1);
            run_x(op, 1'b0, 20'h00050, 1, 8'h74, 1'b0, "R7");
            sc_fill(8'h00, 8'hC0, 5'd1);
            run_x(op, 1'b0, 20'h00050, 1, 8'h75, 1'b0, "R7");
            sc_fill(8'h00, 8'h00, 5'd0);
            run_x(op, 1'b0, 20'h00050, 1, 8'h76, 1'b0, "R7");
            sc_fill(8'h00, 8'h00, 5'd3);
            run_x(op, 1'b0, 20'h00050, 1, 8'h77, 1'b0, "R7");
        end

        // Requests while busy are dropped
        sc_fill(8'h00, 8'h00, 5'd6);
        sc_set(0, 8'h00, 8'h20, 5'd6);
        run_x(1, 1'b0, 20'h0ABCD, 6, 8'h5A, 1'b1, "R10");
        sc_fill(8'h00, 8'h00, 5'd1);
        run_x(2, 1'b0, 20'h00033, 1, 8'h5B, 1'b1, "R10");

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule